// File: doc/BRIEF.md
# Chained Serial Wiper Register

This block is the digital control for a dual 8-bit potentiometer. A host drives three signals: an active-high frame enable, a serial clock and serial data. While the enable is high, each rising edge of the serial clock shifts one data bit into a 17-bit frame register. When the enable drops, the frame is copied into two wiper-code latches and a stack-select latch. The stack select picks which wiper code is presented as the stacked code.

The oldest bit of the frame register is always driven on a cascade output. That output can feed the data input of the next device, so several devices share one three-signal bus. If the last cascade output is fed back to the first data input, the host can read the whole chain by circulating it. All three port inputs are synchronised into the system clock, and their edges are detected there.

Top module: `wiper_chain`

## Requirements
- R1: After reset, both wiper codes, the stack select, the stacked code and the cascade output are all 0.
- R2: While the enable is low, serial clock edges and data changes are ignored. The cascade output and all latches keep their values.
- R3: A frame is sent in this order: the stack-select bit, then wiper 1 MSB first, then wiper 0 MSB first. After exactly 17 bits and a falling enable, the latches hold those three values.
- R4: While the enable is high, the wiper codes and the stack select do not change.
- R5: The latches load on the falling enable. The new values appear three system-clock cycles after the enable input falls, and not before.
- R6: After every accepted serial clock rise, the cascade output shows the oldest bit still held in the frame register. At the start of a transaction, the bit shifted out first is the stack select of the previous frame.
- R7: While the port is idle and a falling enable has been processed, the cascade output equals the latched stack select.
- R8: The stacked code equals wiper 0 when the stack select is 0, and wiper 1 when it is 1.
- R9: If the cascade output is looped back to the data input for 17 serial clocks inside one transaction, the settings are unchanged when the enable falls.
- R10: A transaction of a bit count that is not a multiple of 17 still latches the register as it stands. The result is the old contents moved by that many positions.
- R11: In a transaction of 34 bits, the last 17 bits decide the settings. The first 17 bits leave through the cascade output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Serial frame enable, active high |
| sclk_i | input | 1 | Serial clock; rising edges shift data |
| sdat_i | input | 1 | Serial data input |
| casc_o | output | 1 | Cascade output, oldest frame bit |
| wiper0_o | output | 8 | Latched wiper 0 code |
| wiper1_o | output | 8 | Latched wiper 1 code |
| stack_sel_o | output | 1 | Latched stack select |
| stack_code_o | output | 8 | Wiper code picked by the stack select |

## Verification
Each input passes two synchroniser stages and one edge-detect register. A frame shift or a latch load therefore shows at the outputs on the third system clock after the input changes. The bench drives inputs on falling system-clock edges. For shifts, it samples five cycles later. For loads, it samples both the second and the third falling edges, so the R5 check can tell early loads from late ones. A bit-level model of the frame register in the bench gives the cascade value due after every shift, and the decoded settings due at the end of partial, double and looped-back transactions.

// File: rtl/wiper_chain_pkg.sv
package wiper_chain_pkg;
  localparam int DEF_WIPER_W   = 8;
  localparam int DEF_SYNC_STGS = 2;

  typedef enum logic {
    SEL_WIPER0 = 1'b0,
    SEL_WIPER1 = 1'b1
  } stack_sel_e;
endpackage

// File: rtl/wc_sync.sv
module wc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_s_i,
  input  logic sclk_s_i,
  output logic en_prev_o,
  output logic shift_o,
  output logic load_o
);
  logic sclk_prev_q, en_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      en_prev_q   <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      en_prev_q   <= en_s_i;
    end
  end

  // shift only on serial clock rise inside an open frame
  assign shift_o   = en_s_i & sclk_s_i & ~sclk_prev_q;
  assign load_o    = ~en_s_i & en_prev_q;
  assign en_prev_o = en_prev_q;
endmodule

// File: rtl/wc_shift.sv
module wc_shift #(
  parameter int FRAME_W = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               sdat_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;

  // new bits enter at the top; oldest bit sits at index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frame_q <= '0;
    else if (shift_i) frame_q <= {sdat_i, frame_q[FRAME_W-1:1]};
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/wc_latch.sv
module wc_latch #(
  parameter int WIPER_W = 8,
  localparam int FRAME_W = 2 * WIPER_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               sel_o
);
  logic [WIPER_W-1:0] w0_d, w1_d;

  // index 1 holds wiper 1 MSB, index 1+WIPER_W holds wiper 0 MSB
  for (genvar i = 0; i < WIPER_W; i++) begin : g_map
    assign w1_d[WIPER_W-1-i] = frame_i[1+i];
    assign w0_d[WIPER_W-1-i] = frame_i[1+WIPER_W+i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper0_o <= '0;
      wiper1_o <= '0;
      sel_o    <= 1'b0;
    end else if (load_i) begin
      wiper0_o <= w0_d;
      wiper1_o <= w1_d;
      sel_o    <= frame_i[0];
    end
  end
endmodule

// File: rtl/wiper_chain.sv
module wiper_chain
  import wiper_chain_pkg::*;
#(
  parameter int WIPER_W     = DEF_WIPER_W,
  parameter int SYNC_STAGES = DEF_SYNC_STGS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sclk_i,
  input  logic               sdat_i,
  output logic               casc_o,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               stack_sel_o,
  output logic [WIPER_W-1:0] stack_code_o
);
  localparam int FRAME_W = 2 * WIPER_W + 1;

  logic               en_s, sclk_s, sdat_s;
  logic               en_prev, shift_p, load_p;
  logic [FRAME_W-1:0] frame;
  stack_sel_e         sel;

  wc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({en_i, sclk_i, sdat_i}),
    .q_o    ({en_s, sclk_s, sdat_s})
  );

  wc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_s_i    (en_s),
    .sclk_s_i  (sclk_s),
    .en_prev_o (en_prev),
    .shift_o   (shift_p),
    .load_o    (load_p)
  );

  wc_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_p),
    .sdat_i  (sdat_s),
    .frame_o (frame)
  );

  wc_latch #(.WIPER_W(WIPER_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_p),
    .frame_i  (frame),
    .wiper0_o (wiper0_o),
    .wiper1_o (wiper1_o),
    .sel_o    (stack_sel_o)
  );

  assign casc_o       = frame[0];
  assign sel          = stack_sel_e'(stack_sel_o);
  assign stack_code_o = (sel == SEL_WIPER1) ? wiper1_o : wiper0_o;
endmodule

// File: rtl/wiper_chain_chk.sv
module wiper_chain_chk #(
  parameter int WIPER_W = 8,
  localparam int FRAME_W = 2 * WIPER_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_lvl,
  input logic               en_prev,
  input logic               shift_p,
  input logic               load_p,
  input logic [FRAME_W-1:0] frame,
  input logic               casc_o,
  input logic [WIPER_W-1:0] wiper0_o,
  input logic [WIPER_W-1:0] wiper1_o,
  input logic               stack_sel_o
);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_lvl |=> $stable(casc_o));

  // R4
  wiper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_lvl |=> ($stable(wiper0_o) && $stable(wiper1_o) && $stable(stack_sel_o)));

  // R5
  load_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_p |=> (stack_sel_o == $past(frame[0]) &&
                wiper1_o[WIPER_W-1] == $past(frame[1]) &&
                wiper0_o[0] == $past(frame[FRAME_W-1])));

  // R6
  casc_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_p |=> casc_o == $past(frame[1]));

  // R7
  idle_casc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_lvl && !en_prev) |-> casc_o == stack_sel_o);
endmodule

bind wiper_chain wiper_chain_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_lvl      (en_s),
  .en_prev     (en_prev),
  .shift_p     (shift_p),
  .load_p      (load_p),
  .frame       (frame),
  .casc_o      (casc_o),
  .wiper0_o    (wiper0_o),
  .wiper1_o    (wiper1_o),
  .stack_sel_o (stack_sel_o)
);

// File: tb/wiper_chain_bench.sv
`timescale 1ns/1ps
module wiper_chain_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic       casc, sel;
  logic [7:0] w0, w1, code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [16:0] model = '0;

  // {stack_sel, wiper1, wiper0}
  localparam logic [16:0] VEC [5] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b1, 8'h81, 8'h7E},
    {1'b1, 8'hFF, 8'h00},
    {1'b0, 8'h00, 8'hFF},
    {1'b1, 8'h5A, 8'hC3}
  };

  always #10 clk = ~clk;

  wiper_chain u_wiper_chain (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .sclk_i       (sclk),
    .sdat_i       (sdat),
    .casc_o       (casc),
    .wiper0_o     (w0),
    .wiper1_o     (w1),
    .stack_sel_o  (sel),
    .stack_code_o (code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] decode(input logic [16:0] r);
    logic [7:0] a, b;
    for (int i = 0; i < 8; i++) begin
      a[7-i] = r[1+i];
      b[7-i] = r[9+i];
    end
    return {r[0], a, b};
  endfunction

  task automatic open_tx();
    @(negedge clk) en = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit loop);
    @(negedge clk);
    sdat = loop ? casc : b;
    repeat (5) @(negedge clk);
    sclk = 1'b1;
    model = {sdat, model[16:1]};
    repeat (5) @(negedge clk);
    check("R6 cascade after shift", casc, model[0]);
    sclk = 1'b0;
  endtask

  task automatic close_tx(input string req);
    logic [16:0] old_s, exp_s;
    old_s = {sel, w1, w0};
    exp_s = decode(model);
    @(negedge clk) en = 1'b0;
    repeat (2) @(negedge clk);
    check("R4/R5 no early load", {sel, w1, w0}, old_s);
    @(negedge clk);
    check(req, {sel, w1, w0}, exp_s);
    check("R8 stacked code", code, exp_s[16] ? exp_s[15:8] : exp_s[7:0]);
    repeat (2) @(negedge clk);
    check("R7 idle cascade", casc, sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    check("R1 reset settings", {sel, w1, w0}, 17'h0);
    check("R1 reset code", code, 8'h00);
    check("R1 reset cascade", casc, 1'b0);

    // table walk: R3, R6, R8
    foreach (VEC[k]) begin
      open_tx();
      for (int i = 16; i >= 0; i--) send_bit(VEC[k][i], 1'b0);
      close_tx("R3 frame latched");
      check("R3 table match", {sel, w1, w0}, VEC[k]);
      check("R8 table code", code, VEC[k][16] ? VEC[k][15:8] : VEC[k][7:0]);
    end

    // R2: serial clock toggles with enable low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) sdat = ~casc;
      repeat (5) @(negedge clk) sclk = 1'b1;
      repeat (5) @(negedge clk) sclk = 1'b0;
      check("R2 idle cascade", casc, model[0]);
      check("R2 idle settings", {sel, w1, w0}, VEC[4]);
    end

    // R9: loopback circulation
    open_tx();
    for (int i = 0; i < 17; i++) send_bit(1'b0, 1'b1);
    close_tx("R9 loopback unchanged");
    check("R9 table match", {sel, w1, w0}, VEC[4]);

    // R10: partial frame of 5 bits
    open_tx();
    for (int i = 0; i < 5; i++) send_bit(i[0], 1'b0);
    close_tx("R10 partial frame");

    // R11: double frame, last one wins
    open_tx();
    for (int i = 16; i >= 0; i--) send_bit(VEC[1][i], 1'b0);
    for (int i = 16; i >= 0; i--) send_bit(VEC[3][i], 1'b0);
    close_tx("R11 double frame");
    check("R11 last frame", {sel, w1, w0}, VEC[3]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule